// File: doc/BRIEF.md
# Field-Based Opcode Decoder

This block turns one 8-bit opcode into the control fields that a small accumulator-style processor needs to run it. It splits the byte into a 2-bit group (`x`, bits 7:6), a 3-bit middle field (`y`, bits 5:3) and a 3-bit low field (`z`, bits 2:0). It then splits `y` further into a pair index (`p`, bits 5:4) and a selector bit (`q`, bit 3). These fields select an instruction class and the operand fields that go with it. A few opcodes are special. The byte 0xCB announces a second opcode byte. The register-to-register move whose source and destination are both the memory operand becomes HALT.

The pipeline stage around the decoder presents an opcode together with `in_valid`. One clock later the decoded fields appear together with `out_valid`. The fields then hold until the next valid opcode arrives. Instruction execution, fetching of immediate bytes and decoding of the byte after the prefix all take place outside the block. The class values are the `op_class_e` enumeration of the package `opdec_pkg`, so a consumer compares them by name.

Top module: `opdec`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the block shows `out_valid`=0, class NOP, `illegal`=0, `prefix`=0, `len`=1 and every select field at 0.
- R2: A decode registered from `opcode` with `in_valid`=1 appears one clock later with `out_valid`=1. When `in_valid`=0, `out_valid` goes to 0 on the next clock and every decoded field holds its value.
- R3: In the register index, 0..7 means B, C, D, E, H, L, memory at HL, A. Group x=1 is MOVE with `dst_reg`=y and `src_reg`=z, except opcode 0x76, which is class HALT.
- R4: Group x=2 is ALU_R with `alu_sel`=y (0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 AND, 5 XOR, 6 OR, 7 CP), `src_reg`=z and `dst_reg`=7. For x=3, z=6 the class is ALU_IMM with `alu_sel`=y.
- R5: For x=0, z=1 the class is LD_RP_IMM (q=0) or ADD_HL_RP (q=1). For x=0, z=3 it is INC16 (q=0) or DEC16 (q=1). In all four, `pair_sel`=p, where 0 BC, 1 DE, 2 HL, 3 SP, and `pair_alt`=0.
- R6: For x=0, z=2 the class is ST_A_IND (q=0) or LD_A_IND (q=1), with `pair_sel`=p. `addr_adj` is 0 for p=0 and p=1, 1 (post-increment HL) for p=2, and 2 (post-decrement HL) for p=3.
- R7: For x=0, z=4/5/6 the class is INC8, DEC8 or LD_R_IMM with `dst_reg`=y. For x=0, z=7 the class is ACC_OP with `alu_sel`=y (0 RLCA, 1 RRCA, 2 RLA, 3 RRA, 4 DAA, 5 CPL, 6 SCF, 7 CCF).
- R8: The following forms have `cond_en`=1 and `cond_sel`=y[1:0] (0 not-zero, 1 zero, 2 no-carry, 3 carry):
  - JR with y=4..7 (x=0, z=0);
  - RET with y=0..3 (x=3, z=0);
  - JP with y=0..3 (x=3, z=2);
  - CALL with y=0..3 (x=3, z=4).

  The unconditional forms 0x18, 0xC9, 0xC3 and 0xCD have `cond_en`=0.
- R9: POP (x=3, z=1, q=0) and PUSH (x=3, z=5, q=0) set `pair_alt`=1 and `pair_sel`=p, where 3 means AF. No other class sets `pair_alt`.
- R10: For x=3, z=7 the class is RST and `rst_vec`=y*8. For every other class `rst_vec`=0.
- R11: The high-page classes take the page address 0xFF00:
  - for x=3, z=0, y=4/6, LDH_ST or LDH_LD, offset by an immediate byte;
  - for x=3, z=2, y=4/6, LDH_ST_C or LDH_LD_C, offset by register C.

  For y=5/7 of the same groups the classes are ADD_SP_OFS, LD_HL_SPOFS, ST_A_ABS and LD_A_ABS.
- R12: Opcode 0xCB gives class PREFIX, `prefix`=1, `len`=2 and `illegal`=0. No other opcode sets `prefix`.
- R13: Exactly 11 opcodes set `illegal`: 0xD3, 0xDB, 0xE3, 0xEB, 0xE4, 0xEC, 0xF4, 0xFC, 0xDD, 0xED, 0xFD. On these the class is NOP, `len` is 1 and the select fields are 0.
- R14: `len` gives the instruction length in bytes:
  - 3 when a 16-bit immediate follows: 0x08, LD_RP_IMM, JP with an immediate, CALL, ST_A_ABS, LD_A_ABS;
  - 2 when one extra byte follows: JR, LD_R_IMM, LDH_ST, LDH_LD, ADD_SP_OFS, LD_HL_SPOFS, ALU_IMM, PREFIX;
  - 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Opcode present this cycle |
| opcode | input | 8 | Opcode byte to decode |
| out_valid | output | 1 | Decoded fields belong to the opcode of the previous cycle |
| cls | output | 6 | Instruction class (`op_class_e`) |
| dst_reg | output | 3 | Destination register index |
| src_reg | output | 3 | Source register index |
| pair_sel | output | 2 | Register pair / address mode index |
| pair_alt | output | 1 | Pair index 3 means AF instead of SP |
| addr_adj | output | 2 | HL adjust after access: 0 none, 1 inc, 2 dec |
| alu_sel | output | 3 | ALU or accumulator operation select |
| cond_en | output | 1 | Instruction is conditional |
| cond_sel | output | 2 | Condition index |
| len | output | 2 | Instruction length in bytes |
| rst_vec | output | 8 | Restart target address |
| prefix | output | 1 | Opcode is the prefix byte |
| illegal | output | 1 | Opcode is unused |

## Verification
If a field is split wrongly, or a branch of the pattern table is taken wrongly, the error shows up in the registered outputs one cycle after the opcode is presented. It also repeats every time an opcode that shares that field value is decoded. A single wrong branch can stay hidden for a whole opcode family. For that reason a sweep of every byte compares `illegal`, `prefix` and `len` against the fixed unused set, and vectors cover each group and each `q`/`p` split. A corrupted hold path does not show up on the cycle it occurs. It shows up only as fields that change while `out_valid` is low.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int OPC_W  = 8;
  localparam int GRP_W  = 2;
  localparam int MID_W  = 3;
  localparam int LOW_W  = 3;
  localparam int PAIR_W = MID_W - 1;
  localparam int REG_W  = LOW_W;
  localparam int ALU_W  = MID_W;
  localparam int COND_W = 2;
  localparam int LEN_W  = 2;
  localparam int ADJ_W  = 2;
  localparam int CLS_W  = 6;
  localparam int VEC_W  = OPC_W;
  localparam int VEC_SH = VEC_W - MID_W;

  typedef enum logic [CLS_W-1:0] {
    CLS_NOP, CLS_ST_SP_ABS, CLS_STOP, CLS_JR, CLS_LD_RP_IMM, CLS_ADD_HL_RP,
    CLS_ST_A_IND, CLS_LD_A_IND, CLS_INC16, CLS_DEC16, CLS_INC8, CLS_DEC8,
    CLS_LD_R_IMM, CLS_ACC_OP, CLS_HALT, CLS_MOVE, CLS_ALU_R, CLS_RET,
    CLS_LDH_ST, CLS_ADD_SP_OFS, CLS_LDH_LD, CLS_LD_HL_SPOFS, CLS_POP, CLS_RETI,
    CLS_JP_HL, CLS_LD_SP_HL, CLS_JP, CLS_LDH_ST_C, CLS_ST_A_ABS, CLS_LDH_LD_C,
    CLS_LD_A_ABS, CLS_DI, CLS_EI, CLS_CALL, CLS_PUSH, CLS_ALU_IMM, CLS_RST,
    CLS_PREFIX
  } op_class_e;

  typedef struct packed {
    logic [GRP_W-1:0]  x;
    logic [MID_W-1:0]  y;
    logic [LOW_W-1:0]  z;
    logic [PAIR_W-1:0] p;
    logic              q;
  } op_fields_t;

  typedef struct packed {
    op_class_e         cls;
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  src;
    logic [PAIR_W-1:0] pair;
    logic              alt;
    logic [ADJ_W-1:0]  adj;
    logic [ALU_W-1:0]  alu;
    logic              cen;
    logic [COND_W-1:0] csel;
    logic [VEC_W-1:0]  vec;
    logic              pre;
    logic              ill;
  } op_dec_t;
endpackage

// File: rtl/opdec_fields.sv
module opdec_fields
  import opdec_pkg::*;
(
  input  logic [OPC_W-1:0] op,
  output op_fields_t       f
);
  always_comb begin
    f.x = op[OPC_W-1 -: GRP_W];
    f.y = op[LOW_W +: MID_W];
    f.z = op[LOW_W-1:0];
    f.p = op[LOW_W+1 +: PAIR_W];
    f.q = op[LOW_W];
  end
endmodule

// File: rtl/opdec_table.sv
module opdec_table
  import opdec_pkg::*;
(
  input  op_fields_t f,
  output op_dec_t    d
);
  localparam logic [REG_W-1:0] REG_A = '1;

  always_comb begin
    d = '0;
    d.cls = CLS_NOP;
    unique case (f.x)
      2'd0: begin
        unique case (f.z)
          3'd0: begin
            unique case (f.y)
              3'd0: d.cls = CLS_NOP;
              3'd1: d.cls = CLS_ST_SP_ABS;
              3'd2: d.cls = CLS_STOP;
              default: begin
                d.cls  = CLS_JR;
                d.cen  = f.y[2];
                d.csel = f.y[2] ? f.y[1:0] : '0;
              end
            endcase
          end
          3'd1: begin
            d.pair = f.p;
            d.cls  = f.q ? CLS_ADD_HL_RP : CLS_LD_RP_IMM;
          end
          3'd2: begin
            d.pair = f.p;
            d.cls  = f.q ? CLS_LD_A_IND : CLS_ST_A_IND;
            d.adj  = (f.p == 2'd2) ? 2'd1 : (f.p == 2'd3) ? 2'd2 : 2'd0;
          end
          3'd3: begin
            d.pair = f.p;
            d.cls  = f.q ? CLS_DEC16 : CLS_INC16;
          end
          3'd4: begin d.cls = CLS_INC8;    d.dst = f.y; end
          3'd5: begin d.cls = CLS_DEC8;    d.dst = f.y; end
          3'd6: begin d.cls = CLS_LD_R_IMM; d.dst = f.y; end
          default: begin d.cls = CLS_ACC_OP; d.alu = f.y; end
        endcase
      end
      2'd1: begin
        if (f.z == 3'd6 && f.y == 3'd6) d.cls = CLS_HALT;
        else begin
          d.cls = CLS_MOVE;
          d.dst = f.y;
          d.src = f.z;
        end
      end
      2'd2: begin
        d.cls = CLS_ALU_R;
        d.alu = f.y;
        d.src = f.z;
        d.dst = REG_A;
      end
      default: begin
        unique case (f.z)
          3'd0: begin
            if (!f.y[2]) begin
              d.cls = CLS_RET; d.cen = 1'b1; d.csel = f.y[1:0];
            end else begin
              unique case (f.y[1:0])
                2'd0: d.cls = CLS_LDH_ST;
                2'd1: d.cls = CLS_ADD_SP_OFS;
                2'd2: d.cls = CLS_LDH_LD;
                default: d.cls = CLS_LD_HL_SPOFS;
              endcase
            end
          end
          3'd1: begin
            if (!f.q) begin
              d.cls = CLS_POP; d.pair = f.p; d.alt = 1'b1;
            end else begin
              unique case (f.p)
                2'd0: d.cls = CLS_RET;
                2'd1: d.cls = CLS_RETI;
                2'd2: d.cls = CLS_JP_HL;
                default: d.cls = CLS_LD_SP_HL;
              endcase
            end
          end
          3'd2: begin
            if (!f.y[2]) begin
              d.cls = CLS_JP; d.cen = 1'b1; d.csel = f.y[1:0];
            end else begin
              unique case (f.y[1:0])
                2'd0: d.cls = CLS_LDH_ST_C;
                2'd1: d.cls = CLS_ST_A_ABS;
                2'd2: d.cls = CLS_LDH_LD_C;
                default: d.cls = CLS_LD_A_ABS;
              endcase
            end
          end
          3'd3: begin
            unique case (f.y)
              3'd0: d.cls = CLS_JP;
              3'd1: begin d.cls = CLS_PREFIX; d.pre = 1'b1; end
              3'd6: d.cls = CLS_DI;
              3'd7: d.cls = CLS_EI;
              default: d.ill = 1'b1;
            endcase
          end
          3'd4: begin
            if (!f.y[2]) begin
              d.cls = CLS_CALL; d.cen = 1'b1; d.csel = f.y[1:0];
            end else d.ill = 1'b1;
          end
          3'd5: begin
            if (!f.q) begin
              d.cls = CLS_PUSH; d.pair = f.p; d.alt = 1'b1;
            end else if (f.p == 2'd0) d.cls = CLS_CALL;
            else d.ill = 1'b1;
          end
          3'd6: begin d.cls = CLS_ALU_IMM; d.alu = f.y; end
          default: begin
            d.cls = CLS_RST;
            d.vec = {{VEC_SH{1'b0}}, f.y} << MID_W;
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/opdec_len.sv
module opdec_len
  import opdec_pkg::*;
(
  input  op_class_e        cls,
  output logic [LEN_W-1:0] len
);
  always_comb begin
    unique case (cls)
      CLS_ST_SP_ABS, CLS_LD_RP_IMM, CLS_JP, CLS_CALL,
      CLS_ST_A_ABS, CLS_LD_A_ABS:                       len = 2'd3;
      CLS_JR, CLS_LD_R_IMM, CLS_LDH_ST, CLS_LDH_LD, CLS_ADD_SP_OFS,
      CLS_LD_HL_SPOFS, CLS_ALU_IMM, CLS_PREFIX:          len = 2'd2;
      default:                                          len = 2'd1;
    endcase
  end
endmodule

// File: rtl/opdec.sv
module opdec
  import opdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  opcode,
  output logic              out_valid,
  output logic [CLS_W-1:0]  cls,
  output logic [REG_W-1:0]  dst_reg,
  output logic [REG_W-1:0]  src_reg,
  output logic [PAIR_W-1:0] pair_sel,
  output logic              pair_alt,
  output logic [ADJ_W-1:0]  addr_adj,
  output logic [ALU_W-1:0]  alu_sel,
  output logic              cond_en,
  output logic [COND_W-1:0] cond_sel,
  output logic [LEN_W-1:0]  len,
  output logic [VEC_W-1:0]  rst_vec,
  output logic              prefix,
  output logic              illegal
);
  op_fields_t       fld;
  op_dec_t          dec_c, dec_q;
  logic [LEN_W-1:0] len_c, len_q;

  opdec_fields u_fields (.op(opcode), .f(fld));
  opdec_table  u_table  (.f(fld), .d(dec_c));
  opdec_len    u_len    (.cls(dec_c.cls), .len(len_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dec_q     <= '0;
      len_q     <= 2'd1;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dec_q <= dec_c;
        len_q <= len_c;
      end
    end
  end

  assign cls      = dec_q.cls;
  assign dst_reg  = dec_q.dst;
  assign src_reg  = dec_q.src;
  assign pair_sel = dec_q.pair;
  assign pair_alt = dec_q.alt;
  assign addr_adj = dec_q.adj;
  assign alu_sel  = dec_q.alu;
  assign cond_en  = dec_q.cen;
  assign cond_sel = dec_q.csel;
  assign len      = len_q;
  assign rst_vec  = dec_q.vec;
  assign prefix   = dec_q.pre;
  assign illegal  = dec_q.ill;
endmodule

// File: rtl/opdec_checker.sv
module opdec_checker
  import opdec_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [CLS_W-1:0] cls,
  input logic [LEN_W-1:0] len,
  input logic [VEC_W-1:0] rst_vec,
  input logic             pair_alt,
  input logic             prefix,
  input logic             illegal
);
  assert_len_range_R14: assert property (@(posedge clk) disable iff (rst)
    len != 2'd0);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(cls) && $stable(len)));

  assert_illegal_is_nop_R13: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (cls == CLS_NOP && len == 2'd1 && !prefix));

  assert_prefix_len_R12: assert property (@(posedge clk) disable iff (rst)
    prefix |-> (!illegal && len == 2'd2 && cls == CLS_PREFIX));

  assert_vec_only_rst_R10: assert property (@(posedge clk) disable iff (rst)
    (rst_vec != '0) |-> (cls == CLS_RST));

  assert_alt_only_stack_R9: assert property (@(posedge clk) disable iff (rst)
    pair_alt |-> (cls == CLS_PUSH || cls == CLS_POP));
endmodule

bind opdec opdec_checker u_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .cls(cls), .len(len), .rst_vec(rst_vec), .pair_alt(pair_alt),
  .prefix(prefix), .illegal(illegal)
);

// File: tb/opdec_bench.sv
`timescale 1ns/1ps
module opdec_bench;
  import opdec_pkg::*;

  typedef struct packed {
    logic [7:0] op;
    op_class_e  cls;
    logic [2:0] dst;
    logic [2:0] src;
    logic [1:0] pair;
    logic       alt;
    logic [1:0] adj;
    logic [2:0] alu;
    logic       cen;
    logic [1:0] csel;
    logic [1:0] len;
    logic [7:0] vec;
    logic       pre;
    logic       ill;
  } vec_t;

  localparam int NV = 32;
  // op cls dst src pair alt adj alu cen csel len vec pre ill
  localparam vec_t TBL [NV] = '{
    '{8'h00, CLS_NOP,         3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R14
    '{8'h08, CLS_ST_SP_ABS,   3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd3,8'h00,1'b0,1'b0}, // R14
    '{8'h20, CLS_JR,          3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b1,2'd0,2'd2,8'h00,1'b0,1'b0}, // R8
    '{8'h18, CLS_JR,          3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd2,8'h00,1'b0,1'b0}, // R8
    '{8'h21, CLS_LD_RP_IMM,   3'd0,3'd0,2'd2,1'b0,2'd0,3'd0,1'b0,2'd0,2'd3,8'h00,1'b0,1'b0}, // R5
    '{8'h39, CLS_ADD_HL_RP,   3'd0,3'd0,2'd3,1'b0,2'd0,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R5
    '{8'h22, CLS_ST_A_IND,    3'd0,3'd0,2'd2,1'b0,2'd1,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R6
    '{8'h3A, CLS_LD_A_IND,    3'd0,3'd0,2'd3,1'b0,2'd2,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R6
    '{8'h1B, CLS_DEC16,       3'd0,3'd0,2'd1,1'b0,2'd0,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R5
    '{8'h3C, CLS_INC8,        3'd7,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R7
    '{8'h35, CLS_DEC8,        3'd6,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R7
    '{8'h0E, CLS_LD_R_IMM,    3'd1,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd2,8'h00,1'b0,1'b0}, // R7
    '{8'h1F, CLS_ACC_OP,      3'd0,3'd0,2'd0,1'b0,2'd0,3'd3,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R7
    '{8'h76, CLS_HALT,        3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R3
    '{8'h41, CLS_MOVE,        3'd0,3'd1,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R3
    '{8'h7E, CLS_MOVE,        3'd7,3'd6,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R3
    '{8'h9A, CLS_ALU_R,       3'd7,3'd2,2'd0,1'b0,2'd0,3'd3,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R4
    '{8'hD8, CLS_RET,         3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b1,2'd3,2'd1,8'h00,1'b0,1'b0}, // R8
    '{8'hC9, CLS_RET,         3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R8
    '{8'hE0, CLS_LDH_ST,      3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd2,8'h00,1'b0,1'b0}, // R11
    '{8'hF2, CLS_LDH_LD_C,    3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R11
    '{8'hF1, CLS_POP,         3'd0,3'd0,2'd3,1'b1,2'd0,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R9
    '{8'hC5, CLS_PUSH,        3'd0,3'd0,2'd0,1'b1,2'd0,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b0}, // R9
    '{8'hC2, CLS_JP,          3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b1,2'd0,2'd3,8'h00,1'b0,1'b0}, // R8
    '{8'hC3, CLS_JP,          3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd3,8'h00,1'b0,1'b0}, // R14
    '{8'hCD, CLS_CALL,        3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd3,8'h00,1'b0,1'b0}, // R8
    '{8'hCB, CLS_PREFIX,      3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd2,8'h00,1'b1,1'b0}, // R12
    '{8'hFE, CLS_ALU_IMM,     3'd0,3'd0,2'd0,1'b0,2'd0,3'd7,1'b0,2'd0,2'd2,8'h00,1'b0,1'b0}, // R4
    '{8'hEF, CLS_RST,         3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd1,8'h28,1'b0,1'b0}, // R10
    '{8'hD3, CLS_NOP,         3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd1,8'h00,1'b0,1'b1}, // R13
    '{8'hE8, CLS_ADD_SP_OFS,  3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd2,8'h00,1'b0,1'b0}, // R11
    '{8'hFA, CLS_LD_A_ABS,    3'd0,3'd0,2'd0,1'b0,2'd0,3'd0,1'b0,2'd0,2'd3,8'h00,1'b0,1'b0}  // R11
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        out_valid, pair_alt, cond_en, prefix, illegal;
  logic [5:0]  cls;
  logic [2:0]  dst_reg, src_reg, alu_sel;
  logic [1:0]  pair_sel, addr_adj, cond_sel, len;
  logic [7:0]  rst_vec;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  opdec u_opdec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .out_valid(out_valid), .cls(cls), .dst_reg(dst_reg), .src_reg(src_reg),
    .pair_sel(pair_sel), .pair_alt(pair_alt), .addr_adj(addr_adj),
    .alu_sel(alu_sel), .cond_en(cond_en), .cond_sel(cond_sel), .len(len),
    .rst_vec(rst_vec), .prefix(prefix), .illegal(illegal)
  );

  function automatic vec_t observed(input logic [7:0] op);
    vec_t v;
    v.op = op; v.cls = op_class_e'(cls); v.dst = dst_reg; v.src = src_reg;
    v.pair = pair_sel; v.alt = pair_alt; v.adj = addr_adj; v.alu = alu_sel;
    v.cen = cond_en; v.csel = cond_sel; v.len = len; v.vec = rst_vec;
    v.pre = prefix; v.ill = illegal;
    return v;
  endfunction

  function automatic bit unused_op(input logic [7:0] op);
    return op inside {8'hD3, 8'hDB, 8'hE3, 8'hEB, 8'hE4, 8'hEC,
                      8'hF4, 8'hFC, 8'hDD, 8'hED, 8'hFD};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op);
    @(negedge clk);
    opcode = op; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    vec_t got;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!out_valid && cls == CLS_NOP && !illegal && !prefix && len == 2'd1
          && rst_vec == 0 && pair_sel == 0 && !cond_en, "R1 reset",
          {out_valid, cls, illegal, prefix, len}, {1'b0, 6'd0, 1'b0, 1'b0, 2'd1});
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && cls == CLS_NOP && len == 2'd1, "R1 after reset",
          {out_valid, cls, len}, {1'b0, 6'd0, 2'd1});

    // table walk: R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 R13 R14
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].op);
      got = observed(TBL[i].op);
      check(got == TBL[i] && out_valid, "R2 table vector", 64'(got), 64'(TBL[i]));
    end

    // R2: fields hold and out_valid drops while in_valid is low
    apply(8'h80);
    opcode = 8'h76;
    @(negedge clk); @(negedge clk);
    check(!out_valid && cls == CLS_ALU_R && dst_reg == 3'd7 && alu_sel == 3'd0,
          "R2 hold", {out_valid, cls, dst_reg}, {1'b0, 6'(CLS_ALU_R), 3'd7});

    // R10: every restart vector
    for (int y = 0; y < 8; y++) begin
      apply(8'hC7 | 8'(y << 3));
      check(cls == CLS_RST && rst_vec == 8'(y * 8), "R10 restart",
            {cls, rst_vec}, {6'(CLS_RST), 8'(y * 8)});
    end

    // R8: conditional JR forms
    for (int y = 4; y < 8; y++) begin
      apply(8'h00 | 8'(y << 3));
      check(cls == CLS_JR && cond_en && cond_sel == 2'(y - 4) && len == 2'd2,
            "R8 jr cond", {cls, cond_en, cond_sel}, {6'(CLS_JR), 1'b1, 2'(y - 4)});
    end

    // R13 R12: sweep every byte for the unused set and the prefix flag
    for (int b = 0; b < 256; b++) begin
      apply(8'(b));
      check(illegal == unused_op(8'(b)) && prefix == (b == 8'hCB)
            && (!illegal || (cls == CLS_NOP && len == 2'd1 && pair_sel == 0
                             && dst_reg == 0 && !cond_en)),
            "R13 sweep", {8'(b), illegal, prefix, cls, len},
            {8'(b), unused_op(8'(b)), b == 8'hCB, 6'd0, 2'd1});
    end

    // R1: reset in mid-stream clears decode
    apply(8'hFF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(!out_valid && cls == CLS_NOP && rst_vec == 0 && len == 2'd1,
          "R1 mid reset", {out_valid, cls, rst_vec}, {1'b0, 6'd0, 8'd0});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule